// File: doc/BRIEF.md
# Half-Band Rate-Change Sequencer

This block sits around a fixed-coefficient half-band filter core and handles the 2x change of sampling rate. When upsampling by two, it takes one input word every other clock and gives the core a zero on each clock in between. When downsampling by two, it passes every input word to the core but updates its output register only every other clock. It also has an equal-rate mode, where every clock both feeds the core and loads the output, and a bypass mode, where the input goes through a fixed delay line to the output and the core is skipped.

A single internal phase bit sets which clock edges are "even" and which are "odd". Any edge that samples `sync_i` high is an even edge, and from then on even and odd alternate. After `sync_i` goes low, the host can hold it low, or drive it high on even edges only, and the behaviour is the same in both cases. A two-channel option marks each sample sent to the core as belonging to channel A or channel B. This lets the core keep a separate history for each of two interleaved streams.

Top module: `rate_seq`

## Requirements
- R1: Interpolate mode (`mode_i`=0): each edge in odd phase registers `din_i` into `core_din_o` with `core_valid_o`=1. Each edge in even phase registers zero with `core_valid_o`=0.
- R2: An edge that samples `sync_i`=1 is an even edge. The edge after it is odd. After that, even and odd alternate on each edge while `sync_i` stays low.
- R3: Once aligned, the results are the same whether `sync_i` is held low or driven high only on even edges.
- R4: Decimate mode (`mode_i`=1): `dout_o` loads `core_dout_i` and `dout_upd_o` goes to 1 only on even edges. On odd edges `dout_o` holds and `dout_upd_o`=0. The core is fed `din_i` on every edge with `core_valid_o`=1.
- R5: Equal-rate mode (`mode_i`=2): every edge feeds `din_i` to the core and loads `core_dout_i` into `dout_o`, whatever the level of `sync_i`.
- R6: Bypass mode (`mode_i`=3): `dout_o` is `din_i` placed in its upper IN_W bits with zero lower bits. The delay is DLY+1 edges, with default DLY=33, which gives 34 edges. `dout_o` loads on every edge.
- R7: With `two_ch_i`=1 in interpolate or decimate mode, `core_ch_o` is 0 (channel A) for the first sample accepted after an edge with `sync_i`=1. It then flips on each accepted sample. In the other modes, or with `two_ch_i`=0, it is 0.
- R8: Synchronous reset clears all outputs and the delay line. The first edge after reset is an even edge.
- R9: `dout_o` never changes on an edge that leaves `dout_upd_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | 0 interpolate, 1 decimate, 2 equal-rate, 3 bypass |
| two_ch_i | input | 1 | Two interleaved channels |
| sync_i | input | 1 | Phase alignment; high forces an even edge |
| din_i | input | IN_W | Input samples |
| core_din_o | output | IN_W | Zero-stuffed sample to the filter core |
| core_valid_o | output | 1 | Sample on core_din_o is real data |
| core_ch_o | output | 1 | Channel tag of core_din_o (0 = A) |
| core_dout_i | input | OUT_W | Filter core result |
| dout_o | output | OUT_W | Held output register |
| dout_upd_o | output | 1 | dout_o was loaded on the last edge |

## Verification
The hardest case to reach is a `sync_i` pulse that lands on an edge which is already even, because it must leave the phase exactly as it was. A `sync_i` pulse on an odd edge would shift the phase, so the case only shows up when the host sends a correctly timed half-rate square wave. The stimulus table does this in interpolate mode, driving `sync_i` high on the even edges only. A directed decimate sequence then does the same against the output register, and checks that holds and updates still fall on the same edges as with `sync_i` held low.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    RS_INTERP = 2'd0,
    RS_DECIM  = 2'd1,
    RS_EQUAL  = 2'd2,
    RS_BYPASS = 2'd3
  } rs_mode_e;
endpackage

// File: rtl/rs_phase.sv
// Even/odd phase bit and channel tag tracking.
module rs_phase (
  input  logic clk,
  input  logic rst,
  input  logic sync_i,
  input  logic ch_adv_i,   // a sample was accepted in two-channel use
  output logic odd_o,      // current edge is an odd (data-accept) edge
  output logic ch_o        // channel of the current edge's sample
);
  logic odd_q, ch_q;

  // sync high makes this edge even regardless of stored state
  assign odd_o = sync_i ? 1'b0 : odd_q;
  assign ch_o  = ch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      odd_q <= 1'b0;
      ch_q  <= 1'b0;
    end else begin
      odd_q <= ~odd_o;
      if (sync_i)        ch_q <= 1'b0;
      else if (ch_adv_i) ch_q <= ~ch_q;
    end
  end
endmodule

// File: rtl/rs_stuff.sv
// Zero-stuffing input register toward the filter core.
module rs_stuff #(
  parameter int IN_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take_i,
  input  logic            ch_i,
  input  logic [IN_W-1:0] din_i,
  output logic [IN_W-1:0] core_din_o,
  output logic            core_valid_o,
  output logic            core_ch_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      core_din_o   <= '0;
      core_valid_o <= 1'b0;
      core_ch_o    <= 1'b0;
    end else begin
      core_din_o   <= take_i ? din_i : '0;
      core_valid_o <= take_i;
      core_ch_o    <= ch_i;
    end
  end
endmodule

// File: rtl/rs_hold.sv
// Output register with alternate-edge hold and bypass delay line.
module rs_hold #(
  parameter int IN_W  = 12,
  parameter int OUT_W = 16,
  parameter int DLY   = 33
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             byp_i,
  input  logic [IN_W-1:0]  din_i,
  input  logic [OUT_W-1:0] core_dout_i,
  output logic [OUT_W-1:0] dout_o,
  output logic             dout_upd_o
);
  localparam int PAD = OUT_W - IN_W;

  logic [IN_W-1:0]  tap;
  logic [OUT_W-1:0] byp_val;

  generate
    if (DLY == 0) begin : g_nodly
      assign tap = din_i;
    end else begin : g_dly
      logic [IN_W-1:0] line [DLY];
      for (genvar i = 0; i < DLY; i++) begin : g_stage
        always_ff @(posedge clk) begin
          if (rst)         line[i] <= '0;
          else if (i == 0) line[i] <= din_i;
          else             line[i] <= line[(i == 0) ? 0 : i-1];
        end
      end
      assign tap = line[DLY-1];
    end
  endgenerate

  assign byp_val = OUT_W'(tap) << PAD;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_o     <= '0;
      dout_upd_o <= 1'b0;
    end else begin
      dout_upd_o <= load_i;
      if (load_i) dout_o <= byp_i ? byp_val : core_dout_i;
    end
  end
endmodule

// File: rtl/rate_seq.sv
module rate_seq #(
  parameter int IN_W  = 12,
  parameter int OUT_W = 16,
  parameter int DLY   = 33
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_i,
  input  logic             two_ch_i,
  input  logic             sync_i,
  input  logic [IN_W-1:0]  din_i,
  output logic [IN_W-1:0]  core_din_o,
  output logic             core_valid_o,
  output logic             core_ch_o,
  input  logic [OUT_W-1:0] core_dout_i,
  output logic [OUT_W-1:0] dout_o,
  output logic             dout_upd_o
);
  import rs_pkg::*;

  rs_mode_e mode;
  logic odd, ch, take, load, two_en;

  assign mode   = rs_mode_e'(mode_i);
  assign two_en = two_ch_i && (mode == RS_INTERP || mode == RS_DECIM);
  assign take   = (mode == RS_INTERP) ? odd : 1'b1;
  assign load   = (mode == RS_DECIM) ? ~odd : 1'b1;

  rs_phase u_phase (
    .clk(clk), .rst(rst), .sync_i(sync_i),
    .ch_adv_i(two_en && take), .odd_o(odd), .ch_o(ch)
  );

  rs_stuff #(.IN_W(IN_W)) u_stuff (
    .clk(clk), .rst(rst), .take_i(take), .ch_i(two_en && ch),
    .din_i(din_i), .core_din_o(core_din_o),
    .core_valid_o(core_valid_o), .core_ch_o(core_ch_o)
  );

  rs_hold #(.IN_W(IN_W), .OUT_W(OUT_W), .DLY(DLY)) u_hold (
    .clk(clk), .rst(rst), .load_i(load), .byp_i(mode == RS_BYPASS),
    .din_i(din_i), .core_dout_i(core_dout_i),
    .dout_o(dout_o), .dout_upd_o(dout_upd_o)
  );
endmodule

// File: rtl/rate_seq_chk.sv
module rate_seq_chk #(
  parameter int IN_W  = 12,
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode_i,
  input logic             sync_i,
  input logic [IN_W-1:0]  core_din_o,
  input logic             core_valid_o,
  input logic             core_ch_o,
  input logic [OUT_W-1:0] dout_o,
  input logic             dout_upd_o
);
  // R1: an empty slot carries zero
  a_r1_stuffed_zero: assert property (@(posedge clk) disable iff (rst)
    !core_valid_o |-> core_din_o == '0);

  // R1/R2: in interpolate mode an accepted slot is followed by an empty one
  a_r1_alternate: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd0 && $stable(mode_i) && !sync_i && core_valid_o) |=> !core_valid_o);

  // R9: no update flag, no change
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
    !dout_upd_o |-> $stable(dout_o));

  // R5/R6: full-rate modes update and feed every edge
  a_r5_full_rate: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode_i) >= 2'd2) |-> (dout_upd_o && core_valid_o));

  // R7: channel A right after a sync edge
  a_r7_ch_after_sync: assert property (@(posedge clk) disable iff (rst)
    $past(sync_i, 2) |-> !core_ch_o);
endmodule

bind rate_seq rate_seq_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .mode_i(mode_i), .sync_i(sync_i),
  .core_din_o(core_din_o), .core_valid_o(core_valid_o), .core_ch_o(core_ch_o),
  .dout_o(dout_o), .dout_upd_o(dout_upd_o)
);

// File: tb/rate_seq_tb_top.sv
`timescale 1ns/1ps
module rate_seq_tb_top;
  localparam int IN_W  = 12;
  localparam int OUT_W = 16;
  localparam int DLY   = 33;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode_i = 2'd0;
  logic two_ch_i = 1'b0;
  logic sync_i = 1'b0;
  logic [IN_W-1:0] din_i = '0;
  logic [OUT_W-1:0] core_dout_i = '0;
  logic [IN_W-1:0] core_din_o;
  logic core_valid_o, core_ch_o, dout_upd_o;
  logic [OUT_W-1:0] dout_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rate_seq #(.IN_W(IN_W), .OUT_W(OUT_W), .DLY(DLY)) dut_i (
    .clk(clk), .rst(rst), .mode_i(mode_i), .two_ch_i(two_ch_i), .sync_i(sync_i),
    .din_i(din_i), .core_din_o(core_din_o), .core_valid_o(core_valid_o),
    .core_ch_o(core_ch_o), .core_dout_i(core_dout_i), .dout_o(dout_o),
    .dout_upd_o(dout_upd_o)
  );

  // mode, sync, din, expected valid, expected core_din
  typedef struct packed {
    logic [1:0]      m;
    logic            s;
    logic [IN_W-1:0] d;
    logic            ev;
    logic [IN_W-1:0] ed;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b1, 12'h111, 1'b0, 12'h000},  // R2 sync edge is even
    '{2'd0, 1'b0, 12'h222, 1'b1, 12'h222},  // R1 odd accepts
    '{2'd0, 1'b0, 12'h333, 1'b0, 12'h000},  // R1 zero stuffed
    '{2'd0, 1'b0, 12'h444, 1'b1, 12'h444},
    '{2'd0, 1'b1, 12'h555, 1'b0, 12'h000},  // R3 square-wave sync
    '{2'd0, 1'b0, 12'h666, 1'b1, 12'h666},
    '{2'd0, 1'b1, 12'h777, 1'b0, 12'h000},  // R3
    '{2'd0, 1'b0, 12'h0FF, 1'b1, 12'h0FF},
    '{2'd2, 1'b1, 12'h123, 1'b1, 12'h123},  // R5 sync ignored
    '{2'd2, 1'b0, 12'h321, 1'b1, 12'h321}   // R5
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic edge_step();
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    rst = 1'b1; sync_i = 1'b0; two_ch_i = 1'b0; din_i = '0; core_dout_i = '0;
    edge_step(); edge_step();
    chk("R8 reset core_din", core_din_o, 0);
    chk("R8 reset valid", core_valid_o, 0);
    chk("R8 reset dout", dout_o, 0);
    chk("R8 reset upd", dout_upd_o, 0);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    #1;
    do_reset();

    // table walk: R1 R2 R3 R5
    for (int i = 0; i < NV; i++) begin
      mode_i = VECS[i].m; sync_i = VECS[i].s; din_i = VECS[i].d;
      edge_step();
      chk($sformatf("R1/R3/R5 vec%0d valid", i), core_valid_o, VECS[i].ev);
      chk($sformatf("R1/R3/R5 vec%0d data", i), core_din_o, VECS[i].ed);
    end

    // R8: first edge after reset is even, no sync needed
    do_reset();
    mode_i = 2'd0; din_i = 12'hABC;
    edge_step();
    chk("R8 first edge even", core_valid_o, 0);
    edge_step();
    chk("R8 second edge accepts", core_din_o, 12'hABC);

    // R4 decimate with sync, then square-wave sync (R3)
    do_reset();
    mode_i = 2'd1; sync_i = 1'b1; core_dout_i = 16'hA001;
    edge_step();
    chk("R4 even load", dout_o, 16'hA001);
    chk("R4 upd on even", dout_upd_o, 1);
    chk("R4 core fed every edge", core_valid_o, 1);
    sync_i = 1'b0; core_dout_i = 16'hB002;
    edge_step();
    chk("R4 odd hold", dout_o, 16'hA001);
    chk("R4 no upd on odd", dout_upd_o, 0);
    core_dout_i = 16'hC003;
    edge_step();
    chk("R4 next even load", dout_o, 16'hC003);
    core_dout_i = 16'hD004;
    edge_step();
    chk("R4 odd hold again", dout_o, 16'hC003);
    sync_i = 1'b1; core_dout_i = 16'hE005;
    edge_step();
    chk("R3 sync on even keeps phase", dout_o, 16'hE005);
    sync_i = 1'b0; core_dout_i = 16'hF006;
    edge_step();
    chk("R3 following odd holds", dout_o, 16'hE005);

    // R7 two-channel interpolate
    do_reset();
    mode_i = 2'd0; two_ch_i = 1'b1; sync_i = 1'b1; din_i = 12'h001;
    edge_step();
    sync_i = 1'b0; din_i = 12'h0A1;
    edge_step();
    chk("R7 first sample channel A", core_ch_o, 0);
    chk("R7 first sample data", core_din_o, 12'h0A1);
    din_i = 12'h000;
    edge_step();
    din_i = 12'h0B1;
    edge_step();
    chk("R7 second sample channel B", core_ch_o, 1);
    din_i = 12'h000;
    edge_step();
    din_i = 12'h0A2;
    edge_step();
    chk("R7 third sample channel A", core_ch_o, 0);
    mode_i = 2'd2;
    edge_step(); edge_step();
    chk("R7 tag zero in equal-rate", core_ch_o, 0);

    // R6 bypass latency
    do_reset();
    mode_i = 2'd3; din_i = 12'h5A5;
    @(posedge clk); #2;
    din_i = '0;
    repeat (DLY - 1) @(posedge clk);
    #2;
    chk("R6 not yet at DLY edges", dout_o, 0);
    @(posedge clk); #2;
    chk("R6 arrives at DLY+1 edges", dout_o, 16'h5A50);
    chk("R6 updates every edge", dout_upd_o, 1);
    @(posedge clk); #2;
    chk("R6 pulse passes", dout_o, 0);

    finish_run();
  end
endmodule